// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits behind a two-wire serial slave, after the bit shifter and the device address match. Each write transaction has a start event, one word address and any number of data bytes. The block collects those data bytes in a 16-byte page buffer. Nothing reaches the byte-wide memory array while the bytes arrive.

When the closing stop event arrives, the block scans the buffer. It writes each byte loaded in that transaction to the array, one per cycle and in ascending offset order. It then holds a busy state for a fixed number of clock cycles, which stands in for the nonvolatile programming time.

While busy, the block drives its acknowledge decision low and ignores every bus event. An upstream address matcher uses that decision, so acknowledge polling sees no response until the write completes. A write-protect input, a transaction with no data bytes, or a new start before the stop all cancel the commit.

Top module: `page_commit_ctrl`

## Requirements
- R1: Each data byte of a transaction produces exactly one array write, at the address made of the upper word-address bits (bits ADDR_W-1..4, unchanged for the whole transaction) and a 4-bit offset. The offset starts at the low 4 bits of the loaded address and goes up by one per byte.
- R2: The offset counts modulo 16, so the byte after offset 15 is written at offset 0 of the same page.
- R3: When more than 16 bytes arrive, a later byte replaces the earlier one at the same offset. Only the last value is written, and each location is written at most once.
- R4: The array is written only after the stop event, at most one byte per cycle, in ascending offset order 0 to 15.
- R5: busy rises in the cycle after an accepted stop and stays high for exactly 16 + WR_CYCLES clock cycles.
- R6: While busy is high, ack_ok is low, and start, address, data and stop events are ignored. They cause no array writes, now or later.
- R7: If wr_protect is high when the stop is taken, no array write happens and busy stays low.
- R8: A start event clears the buffer, so bytes loaded before a start that was not preceded by a stop are never written.
- R9: A transaction with no data bytes commits nothing and does not raise busy.
- R10: Offsets not loaded in the transaction are not written, so a partial page touches only its own bytes.
- R11: After reset, busy and mem_we are low and ack_ok is high.
- R12: A data byte strobe that arrives after the start but before the word address is loaded is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | One-cycle pulse: start condition seen on the bus |
| bus_stop | input | 1 | One-cycle pulse: stop condition seen on the bus |
| addr_load | input | 1 | One-cycle pulse: word address byte received |
| addr_in | input | ADDR_W | Word address that opens the transaction |
| byte_vld | input | 1 | One-cycle pulse: data byte received |
| byte_in | input | 8 | Received data byte |
| wr_protect | input | 1 | High blocks the commit at stop |
| ack_ok | output | 1 | High when the controller would acknowledge the current byte |
| busy | output | 1 | High during commit and the timed write period |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A corrupted valid mask or offset cursor shows at the ports only after the next stop. It appears as a missing, extra or misplaced array write within the 16 commit cycles that follow, and the scoreboard catches it there. A timer or state fault shows as a wrong busy length, at most 16 + WR_CYCLES cycles after the stop. A leak of bus events into a busy controller appears as writes after busy falls, or as ack_ok going high during the busy window.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    localparam int BYTE_W     = 8;
    localparam int PAGE_BYTES = 16;
    localparam int OFS_W      = $clog2(PAGE_BYTES);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_FILL,
        ST_COMMIT,
        ST_HOLD
    } wr_state_e;

    typedef struct packed {
        logic  vld;
        byte_t data;
    } slot_t;

    function automatic ofs_t ofs_next(ofs_t o);
        return o + ofs_t'(1);
    endfunction

    function automatic logic state_listens(wr_state_e s);
        return (s == ST_IDLE) || (s == ST_OPEN) || (s == ST_FILL);
    endfunction

endpackage

// File: rtl/pgc_page_buf.sv
module pgc_page_buf
    import pgc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  wr_en,
    input  ofs_t  wr_idx,
    input  byte_t wr_data,
    input  ofs_t  rd_idx,
    output slot_t rd_slot,
    output logic  any_vld
);

    logic [PAGE_BYTES-1:0] vld_q;
    byte_t                 data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] hit;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_idx == ofs_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) data_q[i] <= '0;
        end else if (clr) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (hit[i]) begin
                    vld_q[i]  <= 1'b1;
                    data_q[i] <= wr_data;
                end
            end
        end
    end

    assign rd_slot.vld  = vld_q[rd_idx];
    assign rd_slot.data = data_q[rd_idx];
    assign any_vld      = |vld_q;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> !any_vld); // R8

    AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> any_vld); // R10

endmodule

// File: rtl/pgc_cursor.sv
module pgc_cursor
    import pgc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [ADDR_W-1:0]      load_addr,
    input  logic                   step,
    output logic [ADDR_W-OFS_W-1:0] page,
    output ofs_t                   ofs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
            ofs  <= '0;
        end else if (load) begin
            page <= load_addr[ADDR_W-1:OFS_W];
            ofs  <= load_addr[OFS_W-1:0];
        end else if (step) begin
            ofs  <= ofs_next(ofs);
        end
    end

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> $stable(page)); // R2

    AST_OFS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ofs == ofs_t'(PAGE_BYTES-1)) |=> (ofs == '0)); // R2

endmodule

// File: rtl/pgc_wr_timer.sv
module pgc_wr_timer #(
    parameter int CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expire
);

    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expire = (cnt_q == CNT_W'(1));

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5

    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pgc_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              wr_protect,
    output logic              ack_ok,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    localparam int PAGE_W = ADDR_W - OFS_W;

    wr_state_e          state_q, state_d;
    ofs_t               scan_q;
    logic [PAGE_W-1:0]  cur_page;
    ofs_t               cur_ofs;
    slot_t              rd_slot;
    logic               any_vld;
    logic               tmr_expire;
    logic               tmr_load;

    logic listening, take_start, take_addr, take_byte, take_stop, commit_go;

    always_comb begin
        listening  = state_listens(state_q);
        take_start = listening && bus_start;
        take_addr  = (state_q == ST_OPEN) && addr_load && !bus_start;
        take_byte  = (state_q == ST_FILL) && byte_vld && !bus_start;
        take_stop  = (state_q == ST_FILL) && bus_stop && !bus_start;
        commit_go  = take_stop && any_vld && !wr_protect;
        tmr_load   = (state_q == ST_COMMIT) && (scan_q == ofs_t'(PAGE_BYTES-1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_start) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (take_start)                      state_d = ST_OPEN;
                else if (take_addr)                  state_d = ST_FILL;
                else if (bus_stop)                   state_d = ST_IDLE;
            end
            ST_FILL: begin
                if (take_start)                      state_d = ST_OPEN;
                else if (take_stop)                  state_d = commit_go ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                if (tmr_load)                        state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_expire)                      state_d = ST_IDLE;
            end
            default:                                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            scan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (commit_go)                   scan_q <= '0;
            else if (state_q == ST_COMMIT)   scan_q <= ofs_next(scan_q);
        end
    end

    pgc_page_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (take_start),
        .wr_en   (take_byte),
        .wr_idx  (cur_ofs),
        .wr_data (byte_in),
        .rd_idx  (scan_q),
        .rd_slot (rd_slot),
        .any_vld (any_vld)
    );

    pgc_cursor #(.ADDR_W(ADDR_W)) u_cursor (
        .clk       (clk),
        .rst       (rst),
        .load      (take_addr),
        .load_addr (addr_in),
        .step      (take_byte),
        .page      (cur_page),
        .ofs       (cur_ofs)
    );

    pgc_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .expire (tmr_expire)
    );

    assign busy      = (state_q == ST_COMMIT) || (state_q == ST_HOLD);
    assign ack_ok    = !busy;
    assign mem_we    = (state_q == ST_COMMIT) && rd_slot.vld;
    assign mem_addr  = {cur_page, scan_q};
    assign mem_wdata = rd_slot.data;

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_stop)); // R4

    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (bus_stop && wr_protect && !busy) |=> !busy); // R7

    AST_EMPTY_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (bus_stop && !busy && !any_vld) |=> !busy); // R9

    AST_DEAF_START: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_COMMIT) && bus_start) |=> busy); // R6

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_COMMIT) && scan_q != '0)
            |-> (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W]))); // R1

endmodule

// File: tb/page_commit_ctrl_bench.sv
module page_commit_ctrl_bench;

    localparam int ADDR_W = 10;
    localparam int WR_CYC = 40;
    localparam int BUSY_LEN = 16 + WR_CYC;

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [7:0]        d;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_start = 1'b0;
    logic              bus_stop = 1'b0;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              byte_vld = 1'b0;
    logic [7:0]        byte_in = '0;
    logic              wr_protect = 1'b0;
    logic              ack_ok, busy, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;

    int    checks = 0;
    int    errors = 0;
    int    wr_seen = 0;
    int    episodes = 0;
    int    run_len = 0;
    int    last_len = 0;
    bit    finished = 1'b0;
    string cur_req = "R11";
    exp_t  sbq[$];

    always #2 clk = ~clk;

    page_commit_ctrl #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYC)) u_page_commit_ctrl (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_load(addr_load), .addr_in(addr_in), .byte_vld(byte_vld),
        .byte_in(byte_in), .wr_protect(wr_protect), .ack_ok(ack_ok),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard compare and busy-run measurement
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                wr_seen++;
                checks++;
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL %s/R4 unexpected write: actual=%0h:%0h expected=none",
                             cur_req, mem_addr, mem_wdata);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (mem_addr !== e.a || mem_wdata !== e.d) begin
                        errors++;
                        $display("FAIL %s write: actual=%0h:%0h expected=%0h:%0h",
                                 cur_req, mem_addr, mem_wdata, e.a, e.d);
                    end
                end
            end
            if (busy) run_len++;
            else if (run_len != 0) begin
                last_len = run_len;
                run_len  = 0;
                episodes++;
            end
        end
    end

    task automatic p_start();
        bus_start = 1'b1; @(posedge clk); #1 bus_start = 1'b0;
    endtask
    task automatic p_stop();
        bus_stop = 1'b1; @(posedge clk); #1 bus_stop = 1'b0;
    endtask
    task automatic p_addr(input logic [ADDR_W-1:0] a);
        addr_in = a; addr_load = 1'b1; @(posedge clk); #1 addr_load = 1'b0;
    endtask
    task automatic p_byte(input logic [7:0] d);
        byte_in = d; byte_vld = 1'b1; @(posedge clk); #1 byte_vld = 1'b0;
    endtask

    task automatic abort_prefix(input logic [ADDR_W-1:0] a, input int n);
        p_start();
        p_addr(a);
        for (int i = 0; i < n; i++) p_byte(8'(8'hA0 + i));
    endtask

    task automatic run_txn(input string req, input logic [ADDR_W-1:0] a, input int n,
                           input int seed, input bit wp, input bit early, input bit inject);
        logic [7:0] sh_d [16];
        bit         sh_v [16];
        int ep0, wr0, nexp, guard;
        cur_req = req;
        for (int o = 0; o < 16; o++) begin sh_v[o] = 1'b0; sh_d[o] = '0; end
        wr0 = wr_seen;
        ep0 = episodes;
        wr_protect = wp;
        p_start();
        if (early) p_byte(8'hEE);   // R12 stimulus: byte before address
        p_addr(a);
        for (int i = 0; i < n; i++) begin
            int o;
            logic [7:0] d;
            d = 8'(seed + i * 37);
            o = (int'(a[3:0]) + i) % 16;
            sh_d[o] = d;
            sh_v[o] = 1'b1;
            p_byte(d);
        end
        nexp = 0;
        if (!wp) begin
            for (int o = 0; o < 16; o++) begin
                if (sh_v[o]) begin
                    sbq.push_back('{a: {a[ADDR_W-1:4], 4'(o)}, d: sh_d[o]});
                    nexp++;
                end
            end
        end
        chk("R4", wr_seen == wr0, "writes before stop", wr_seen - wr0, 0);
        p_stop();
        if (inject) begin
            @(negedge clk);
            chk("R6", ack_ok == 1'b0, "ack while busy", ack_ok, 0);
            p_start();
            p_addr(10'h3F0);
            p_byte(8'h5A); p_byte(8'h5B); p_byte(8'h5C);
            @(negedge clk);
            chk("R6", ack_ok == 1'b0, "ack while busy after events", ack_ok, 0);
            p_stop();
        end
        guard = 0;
        @(negedge clk);
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
        @(posedge clk); #1;
        chk(req, (episodes - ep0) == ((nexp > 0) ? 1 : 0), "busy episodes",
            episodes - ep0, (nexp > 0) ? 1 : 0);
        if (nexp > 0)
            chk("R5", last_len == BUSY_LEN, "busy length", last_len, BUSY_LEN);
        chk(req, (wr_seen - wr0) == nexp, "write count", wr_seen - wr0, nexp);
        chk(req, sbq.size() == 0, "pending expected writes", sbq.size(), 0);
        wr_protect = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R11", busy == 1'b0, "busy after reset", busy, 0);
        chk("R11", mem_we == 1'b0, "mem_we after reset", mem_we, 0);
        chk("R11", ack_ok == 1'b1, "ack_ok after reset", ack_ok, 1);
        @(posedge clk); #1;

        run_txn("R1",  10'h123, 1,  8'h11, 1'b0, 1'b0, 1'b0);
        run_txn("R1",  10'h2A0, 16, 8'h40, 1'b0, 1'b0, 1'b0);
        run_txn("R2",  10'h0CC, 7,  8'h77, 1'b0, 1'b0, 1'b0);
        run_txn("R3",  10'h355, 20, 8'h09, 1'b0, 1'b0, 1'b0);
        run_txn("R10", 10'h184, 3,  8'hC3, 1'b0, 1'b0, 1'b0);
        run_txn("R7",  10'h200, 4,  8'h21, 1'b1, 1'b0, 1'b0);
        run_txn("R9",  10'h210, 0,  8'h00, 1'b0, 1'b0, 1'b0);
        abort_prefix(10'h100, 5);
        run_txn("R8",  10'h1F8, 2,  8'h90, 1'b0, 1'b0, 1'b0);
        run_txn("R12", 10'h040, 2,  8'h33, 1'b0, 1'b1, 1'b0);
        run_txn("R6",  10'h3A1, 4,  8'h62, 1'b0, 1'b0, 1'b1);
        run_txn("R6",  10'h3B0, 2,  8'h05, 1'b0, 1'b0, 1'b0);
        summary();
    end

endmodule